// File: doc/BRIEF.md
# Time-Step External Spike Injector

This block lets an outside source force spikes into a chosen set of neurons of a spiking-network processor array, lined up with the array's real-time execution steps. The source sends each event as two 4-bit nibbles on two parallel lanes with one valid strobe. A capture stage joins the nibbles into an 8-bit word. Each lane bit goes straight to its own bit of the word, so no serial shifting takes place. The word is a neuron index and is queued in a small FIFO.

A tick input marks the start of each execution step. The period of the tick is set by whoever drives it, nominally one millisecond. When a tick arrives, the block takes note of how many events are queued and drains exactly that many, one per clock cycle. Each drained index sets the matching bit of an injected-spike vector. That vector holds for the whole step and is cleared by the next tick.

A multiplexer then places the injected vector onto the output of one virtual layer, which replaces the spikes the neurons of that layer would have produced. All other layers pass their own neuron outputs through unchanged. A select value of zero picks the first layer.

Top module: `ext_spike_injector`

## Requirements
- R1: An event is taken on each cycle with `lane_vld` high. The event word is `{lane_hi, lane_lo}`, so `lane_hi` forms bits 7:4 and `lane_lo` forms bits 3:0. The word is the index of the neuron to spike.
- R2: An event taken at least two cycles before the cycle in which `step_tick` is high is released by that tick. If k events are pending at a tick, bit i of the injected vector for each index i in [0, NEURONS) is set no later than k cycles after the clock edge that samples the tick.
- R3: An event taken after the clock edge that samples a tick stays queued. It does not appear until the following tick.
- R4: A step with no queued events produces an all-zero injected vector for the whole step.
- R5: Injected bits stay set for the rest of the step. The clock edge that samples the next tick clears all of them.
- R6: An event whose index is NEURONS or more is consumed and sets no bit.
- R7: When DEPTH events are queued, a further event is dropped and `ovf_flag` goes high. The flag stays high until reset. The events already queued are kept.
- R8: The output slice of layer `layer_sel` (bits `layer_sel*NEURONS` upward, NEURONS wide) carries the injected vector. Every other layer slice equals the same slice of `core_spk`. A `layer_sel` of 0 targets the first layer.
- R9: After reset the FIFO is empty, the injected vector is zero and `ovf_flag` is low.
- R10: All events pending at a tick are delivered in the same step, including repeated indices. Their bits are ORed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_hi | input | 4 | Upper nibble of the event word |
| lane_lo | input | 4 | Lower nibble of the event word |
| lane_vld | input | 1 | Both nibble lanes carry an event this cycle |
| step_tick | input | 1 | One-cycle pulse that starts an execution step |
| layer_sel | input | LAYER_W | Virtual layer that receives the injected spikes |
| core_spk | input | LAYERS*NEURONS | Normal spike outputs of all layers |
| spike_out | output | LAYERS*NEURONS | Spike outputs after injection |
| ovf_flag | output | 1 | Sticky FIFO overflow flag |

## Verification
The main path is driven with steps holding one, several, zero and repeated event indices, aimed at different layers. Comparing the full output vector shows both that every pending bit lands and that non-selected layers keep their own spikes. Nibble values with differing upper and lower halves tell a correct lane order from a swapped one. An index above the neuron count distinguishes ignoring the event from wrapping it. Directed cases send an event just after a tick to separate the queue snapshot from a full drain, and overfill the FIFO to check dropping and the sticky flag.

// File: rtl/inj_pkg.sv
package inj_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned EV_W  = 2 * NIB_W;
  typedef logic [EV_W-1:0] ev_word_t;
endpackage

// File: rtl/inj_nibble_join.sv
module inj_nibble_join
  import inj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] nib_hi_i,
  input  logic [NIB_W-1:0] nib_lo_i,
  input  logic             nib_vld_i,
  output ev_word_t         word_o,
  output logic             word_vld_o
);

  ev_word_t word_q, word_n;
  logic     vld_q, vld_n;

  always_comb begin
    vld_n  = nib_vld_i;
    word_n = word_q;
    if (nib_vld_i) begin
      word_n = {nib_hi_i, nib_lo_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_n;
      vld_q  <= vld_n;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;

endmodule

// File: rtl/inj_event_fifo.sv
module inj_event_fifo
  import inj_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  ev_word_t      data_i,
  input  logic          pop_i,
  output ev_word_t      head_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          ovf_o
);

  ev_word_t        mem_q [DEPTH];
  logic [AW-1:0]   wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            ovf_q, ovf_n;
  logic            full, do_wr, do_rd;

  assign full  = (cnt_q == CW'(DEPTH));
  assign do_wr = push_i && !full;
  assign do_rd = pop_i && (cnt_q != '0);

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    ovf_n = ovf_q;
    if (do_wr) begin
      wr_n = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    end
    if (do_rd) begin
      rd_n = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    end
    if (do_wr && !do_rd) begin
      cnt_n = cnt_q + 1'b1;
    end else if (do_rd && !do_wr) begin
      cnt_n = cnt_q - 1'b1;
    end
    if (push_i && full) begin
      ovf_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      mem_q[wr_q] <= data_i;
    end
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign ovf_o   = ovf_q;

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_i && !pop_i) |=> (cnt_q == CW'(DEPTH)) && ovf_q); // R7

endmodule

// File: rtl/inj_step_release.sv
module inj_step_release
  import inj_pkg::*;
#(
  parameter int unsigned NEURONS = 32,
  parameter int unsigned CW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [CW-1:0]      count_i,
  input  logic               empty_i,
  input  ev_word_t           head_i,
  output logic               pop_o,
  output logic [NEURONS-1:0] inj_o
);

  logic [CW-1:0]      pend_q, pend_n;
  logic [NEURONS-1:0] inj_q, inj_n;
  logic [NEURONS-1:0] hit;

  for (genvar g = 0; g < NEURONS; g++) begin : g_dec
    assign hit[g] = (head_i == ev_word_t'(g));
  end

  assign pop_o = !tick_i && (pend_q != '0) && !empty_i;

  always_comb begin
    pend_n = pend_q;
    inj_n  = inj_q;
    if (tick_i) begin
      pend_n = count_i;
      inj_n  = '0;
    end else if (pop_o) begin
      pend_n = pend_q - 1'b1;
      inj_n  = inj_q | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      inj_q  <= '0;
    end else begin
      pend_q <= pend_n;
      inj_q  <= inj_n;
    end
  end

  assign inj_o = inj_q;

  AST_PEND_IN_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= count_i); // R10
  AST_TICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (inj_q == '0)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0 && !tick_i) |=> $stable(inj_q)); // R4

endmodule

// File: rtl/inj_layer_mux.sv
module inj_layer_mux #(
  parameter int unsigned NEURONS = 32,
  parameter int unsigned LAYERS  = 8,
  parameter int unsigned LW      = 3
) (
  input  logic [LW-1:0]             sel_i,
  input  logic [NEURONS-1:0]        inj_i,
  input  logic [LAYERS*NEURONS-1:0] core_i,
  output logic [LAYERS*NEURONS-1:0] out_o
);

  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    assign out_o[l*NEURONS +: NEURONS] =
      (sel_i == LW'(l)) ? inj_i : core_i[l*NEURONS +: NEURONS];
  end

endmodule

// File: rtl/ext_spike_injector.sv
module ext_spike_injector
  import inj_pkg::*;
#(
  parameter int unsigned NEURONS = 32,
  parameter int unsigned LAYERS  = 8,
  parameter int unsigned DEPTH   = 8,
  localparam int unsigned LAYER_W = (LAYERS > 1) ? $clog2(LAYERS) : 1,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1),
  localparam int unsigned OUT_W   = LAYERS * NEURONS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NIB_W-1:0]   lane_hi,
  input  logic [NIB_W-1:0]   lane_lo,
  input  logic               lane_vld,
  input  logic               step_tick,
  input  logic [LAYER_W-1:0] layer_sel,
  input  logic [OUT_W-1:0]   core_spk,
  output logic [OUT_W-1:0]   spike_out,
  output logic               ovf_flag
);

  ev_word_t           word, head;
  logic               word_vld, pop, empty;
  logic [CNT_W-1:0]   count;
  logic [NEURONS-1:0] inj;

  inj_nibble_join u_join (
    .clk        (clk),
    .rst_n      (rst_n),
    .nib_hi_i   (lane_hi),
    .nib_lo_i   (lane_lo),
    .nib_vld_i  (lane_vld),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  inj_event_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (word_vld),
    .data_i  (word),
    .pop_i   (pop),
    .head_o  (head),
    .count_o (count),
    .empty_o (empty),
    .ovf_o   (ovf_flag)
  );

  inj_step_release #(.NEURONS(NEURONS), .CW(CNT_W)) u_rel (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (step_tick),
    .count_i (count),
    .empty_i (empty),
    .head_i  (head),
    .pop_o   (pop),
    .inj_o   (inj)
  );

  inj_layer_mux #(.NEURONS(NEURONS), .LAYERS(LAYERS), .LW(LAYER_W)) u_mux (
    .sel_i  (layer_sel),
    .inj_i  (inj),
    .core_i (core_spk),
    .out_o  (spike_out)
  );

  AST_CAPTURE_TO_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !pop && count < CNT_W'(DEPTH)) |=> (count == $past(count) + 1'b1)); // R1

endmodule

// File: tb/ext_spike_injector_test.sv
module ext_spike_injector_test;
  localparam int N  = 32;
  localparam int L  = 8;
  localparam int D  = 8;
  localparam int OW = N * L;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    lane_hi = '0, lane_lo = '0;
  logic          lane_vld = 1'b0, step_tick = 1'b0;
  logic [2:0]    layer_sel = '0;
  logic [OW-1:0] core_spk = '0;
  logic [OW-1:0] spike_out;
  logic          ovf_flag;
  int            n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ext_spike_injector uut (
    .clk(clk), .rst_n(rst_n), .lane_hi(lane_hi), .lane_lo(lane_lo),
    .lane_vld(lane_vld), .step_tick(step_tick), .layer_sel(layer_sel),
    .core_spk(core_spk), .spike_out(spike_out), .ovf_flag(ovf_flag)
  );

  typedef struct packed {
    logic [2:0]      cnt;
    logic [3:0][7:0] ev;
    logic [2:0]      lay;
    logic [31:0]     exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd1, {8'd0, 8'd0, 8'd0, 8'd5},     3'd0, 32'h0000_0020}, // R2 single
    '{3'd3, {8'd0, 8'd16, 8'd31, 8'd0},   3'd3, 32'h8001_0001}, // R10 several
    '{3'd0, {8'd0, 8'd0, 8'd0, 8'd0},     3'd1, 32'h0000_0000}, // R4 empty step
    '{3'd2, {8'd0, 8'd0, 8'd7, 8'd40},    3'd7, 32'h0000_0080}, // R6 out of range
    '{3'd4, {8'd30, 8'd2, 8'd9, 8'd9},    3'd2, 32'h4000_0204}, // R10 repeats
    '{3'd1, {8'd0, 8'd0, 8'd0, 8'h13},    3'd5, 32'h0008_0000}  // R1 lanes 1/3
  };

  task automatic chk(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] place(input logic [OW-1:0] core, input int lay,
                                          input logic [N-1:0] inj);
    logic [OW-1:0] r = core;
    r[lay*N +: N] = inj;
    return r;
  endfunction

  task automatic send(input logic [7:0] idx);
    @(negedge clk);
    lane_hi = idx[7:4]; lane_lo = idx[3:0]; lane_vld = 1'b1;
  endtask

  task automatic idle(input int n);
    @(negedge clk); lane_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); step_tick = 1'b1;
    @(negedge clk); step_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 spikes", spike_out, '0);
    chk("R9 ovf", {{(OW-1){1'b0}}, ovf_flag}, '0);
    rst_n = 1'b1;
    tick();
    repeat (3) @(negedge clk);
    chk("R9 empty fifo", spike_out, '0);

    for (int i = 0; i < 6; i++) begin
      core_spk  = {L{32'h5A5A_0000 | 32'(i)}};
      layer_sel = VEC[i].lay;
      for (int j = 0; j < int'(VEC[i].cnt); j++) send(VEC[i].ev[j]);
      idle(2);
      tick();
      repeat (int'(VEC[i].cnt) + 2) @(negedge clk);
      chk($sformatf("R2 R8 vec%0d", i), spike_out,
          place(core_spk, int'(VEC[i].lay), VEC[i].exp));
      repeat (20) @(negedge clk);
      chk($sformatf("R5 hold vec%0d", i), spike_out,
          place(core_spk, int'(VEC[i].lay), VEC[i].exp));
    end

    // R8: moving the selection moves the injected slice at once
    core_spk = {L{32'hFFFF_0000}};
    layer_sel = 3'd0;
    #1;
    chk("R8 layer0", spike_out, place(core_spk, 0, 32'h0008_0000));

    // R3: event after tick waits for next step; R5 clearing
    send(8'd3); idle(2);
    tick();
    send(8'd12); idle(2);
    repeat (3) @(negedge clk);
    chk("R3 first step", spike_out, place(core_spk, 0, 32'h0000_0008));
    tick();
    repeat (3) @(negedge clk);
    chk("R3 second step", spike_out, place(core_spk, 0, 32'h0000_1000));
    tick();
    repeat (3) @(negedge clk);
    chk("R5 cleared", spike_out, place(core_spk, 0, 32'h0));

    // R7: overfill the queue
    chk("R7 no ovf yet", {{(OW-1){1'b0}}, ovf_flag}, '0);
    for (int k = 0; k < D + 2; k++) send(8'(k));
    idle(2);
    chk("R7 ovf set", {{(OW-1){1'b0}}, ovf_flag}, {{(OW-1){1'b0}}, 1'b1});
    tick();
    repeat (D + 3) @(negedge clk);
    chk("R7 kept first", spike_out, place(core_spk, 0, 32'h0000_00FF));
    tick();
    repeat (3) @(negedge clk);
    chk("R7 sticky", {{(OW-1){1'b0}}, ovf_flag}, {{(OW-1){1'b0}}, 1'b1});
    chk("R7 dropped gone", spike_out, place(core_spk, 0, 32'h0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule